// File: doc/BRIEF.md
# MSF timecode frame decoder

This block turns the fifteen-byte answer that a radio time receiver gives to a timestamp request into binary time and date fields. The bytes arrive one at a time with a strobe, and a marker on the first byte opens a frame. Thirteen bytes carry decimal digits. They hold the hour, minute and second, then the weekday, then the day, month and two-digit year. A zone byte and a clock status byte follow them.

Every byte is checked for even parity and for its fixed bit pattern. The digits are range-checked. The zone byte must name exactly one of summer time or UTC. The receiver must report that it holds valid time, that a reception has succeeded, and that its last resync did not fail.

When summer time is flagged, the decoder subtracts one hour to return to UTC. If that moves the time back past midnight, it also rolls back the weekday, the day, and where needed the month and year. A stamp that claims summer time in the first hour of the year is refused. The verdict is one pulse, either accept or reject. The time outputs change only on accept. The receiver's status flags are refreshed on every completed frame.

Top module: `msf_frame_decoder`

## Requirements
- R1: A strobed byte with `frame_start` high opens a frame as byte 0. The next strobed bytes without `frame_start` are bytes 1 to 14. The verdict appears in the cycle after the clock edge that takes byte 14. A `frame_start` in the middle of a frame discards it and starts again. Strobed bytes while no frame is open are ignored.
- R2: Bytes 0 to 12 are digits: bits 6..0 must be 0x30 to 0x39, and the digit value is bits 3..0. Byte order: hour tens, hour units, minute tens, minute units, second tens, second units, weekday, day tens, day units, month tens, month units, year tens, year units. Any other value in a digit byte rejects the frame.
- R3: Every byte must have an even number of ones over all 8 bits (bit 7 is the parity bit), else the frame is rejected.
- R4: In bytes 13 and 14, bit 6 must be 0 and bits 5..4 must be 11, else the frame is rejected.
- R5: Ranges: hours 0-23, minutes 0-59, seconds 0-60, weekday 1-7 (1 = Monday, 7 = Sunday), day 1-31, month 1-12, year 0-99. A value outside its range rejects the frame.
- R6: Byte 13 is the zone byte. Bit 1 set means summer time and bit 2 set means UTC. Exactly one of the two must be set, else the frame is rejected. Bit 0 means a zone change is pending. Bits 1 and 0 drive `summer_flag` and `change_pending`.
- R7: Byte 14 is the status byte. Bit 3 means low battery, bit 2 means the last resync failed, bit 1 means a reception succeeded, and bit 0 means the clock holds valid time. These drive the four flag outputs on every completed frame. The frame is accepted only if bits 2..0 are 011.
- R8: With summer time and an hour of 1 or more, the output hour is one less. All other fields pass through unchanged.
- R9: With summer time and hour 0, the output hour is 23 and the weekday steps back (Monday wraps to Sunday, 7). The day steps back. On day 1, the day becomes the last day of the previous month, and January wraps to December of the previous year. Years divisible by 4 give February 29 days.
- R10: A stamp with summer time, hour 0, day 1 and month 1 is rejected.
- R11: `accept` and `reject` are single-cycle pulses and never high together. The time and date outputs hold their values except in a cycle where `accept` is high.
- R12: After reset, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_valid | input | 1 | Strobe for `byte_data` |
| frame_start | input | 1 | Marks the strobed byte as byte 0 of a frame |
| byte_data | input | 8 | Received byte |
| hours | output | 5 | UTC hour |
| minutes | output | 6 | Minute |
| seconds | output | 6 | Second |
| weekday | output | 3 | Day of week, 1 = Monday |
| day | output | 5 | Day of month |
| month | output | 4 | Month |
| year | output | 7 | Two-digit year |
| summer_flag | output | 1 | Summer time flagged in the last frame |
| change_pending | output | 1 | Zone change pending |
| low_battery | output | 1 | Receiver reports low battery |
| resync_failed | output | 1 | Receiver reports a failed last resync |
| rx_ok | output | 1 | Receiver reports a successful reception |
| time_valid | output | 1 | Receiver reports valid time |
| accept | output | 1 | One-cycle pulse: frame accepted |
| reject | output | 1 | One-cycle pulse: frame refused |

## Verification
Every result is registered once. The verdict pulse, the converted time fields and the status flags all appear in the cycle after the clock edge that takes byte 14. The pulse falls again one cycle later. The bench drives each byte at a falling edge and drops the strobe at the next falling edge, so that is where the bench samples a completed frame's outputs. One further falling edge later, it checks that the pulse has gone. For partial frames and stray bytes, the bench checks after every byte that no pulse has appeared and that the held fields have not moved.

// File: rtl/msf_pkg.sv
package msf_pkg;

    localparam int FRAME_BYTES = 15;
    localparam int NUM_DIGITS  = 13;
    localparam int POS_W       = $clog2(FRAME_BYTES);
    localparam int VAL_W       = 7;

    localparam logic [POS_W-1:0] ZONE_POS   = POS_W'(NUM_DIGITS);
    localparam logic [POS_W-1:0] STATUS_POS = POS_W'(FRAME_BYTES - 1);

    // digit slots inside the frame; the order is the wire order
    localparam int D_HT = 0;
    localparam int D_HU = 1;
    localparam int D_MT = 2;
    localparam int D_MU = 3;
    localparam int D_ST = 4;
    localparam int D_SU = 5;
    localparam int D_WD = 6;
    localparam int D_DT = 7;
    localparam int D_DU = 8;
    localparam int D_OT = 9;
    localparam int D_OU = 10;
    localparam int D_YT = 11;
    localparam int D_YU = 12;

    typedef struct packed {
        logic                           active;
        logic [POS_W-1:0]               pos;
        logic                           bad;
        logic [NUM_DIGITS-1:0][3:0]     dig;
        logic [2:0]                     zone;
    } coll_t;

    typedef struct packed {
        logic [4:0] hours;
        logic [5:0] minutes;
        logic [5:0] seconds;
        logic [2:0] weekday;
        logic [4:0] day;
        logic [3:0] month;
        logic [6:0] year;
        logic       summer;
        logic       pending;
        logic       low_batt;
        logic       rs_failed;
        logic       rx_ok;
        logic       t_valid;
        logic       accept;
        logic       reject;
    } res_t;

    function automatic logic [VAL_W-1:0] bcd2bin(input logic [3:0] t, input logic [3:0] u);
        return ({3'b000, t} * 7'd10) + {3'b000, u};
    endfunction

    // every year divisible by four is a leap year
    function automatic logic [4:0] month_days(input logic [3:0] mon, input logic [6:0] yr);
        case (mon)
            4'd2:                      return (yr[1:0] == 2'b00) ? 5'd29 : 5'd28;
            4'd4, 4'd6, 4'd9, 4'd11:   return 5'd30;
            default:                   return 5'd31;
        endcase
    endfunction

endpackage

// File: rtl/msf_byte_check.sv
module msf_byte_check (
    input  logic [7:0] b,
    output logic       parity_ok,
    output logic       frame_bits_ok,
    output logic       digit_ok
);
    // bit 7 makes the count of ones even
    assign parity_ok     = ~^b;
    // digits and status bytes share 0,1,1 in bits 6..4
    assign frame_bits_ok = (b[6:4] == 3'b011);
    assign digit_ok      = frame_bits_ok && (b[3:0] <= 4'd9);
endmodule

// File: rtl/msf_utc_adjust.sv
module msf_utc_adjust
    import msf_pkg::*;
(
    input  logic       summer,
    input  logic [4:0] hour_i,
    input  logic [2:0] wd_i,
    input  logic [4:0] day_i,
    input  logic [3:0] mon_i,
    input  logic [6:0] yr_i,
    output logic [4:0] hour_o,
    output logic [2:0] wd_o,
    output logic [4:0] day_o,
    output logic [3:0] mon_o,
    output logic [6:0] yr_o
);
    always_comb begin
        hour_o = hour_i;
        wd_o   = wd_i;
        day_o  = day_i;
        mon_o  = mon_i;
        yr_o   = yr_i;
        if (summer) begin
            if (hour_i != 5'd0) begin
                hour_o = hour_i - 5'd1;
            end else begin
                hour_o = 5'd23;
                wd_o   = (wd_i == 3'd1) ? 3'd7 : wd_i - 3'd1;
                if (day_i > 5'd1) begin
                    day_o = day_i - 5'd1;
                end else begin
                    if (mon_i == 4'd1) begin
                        mon_o = 4'd12;
                        yr_o  = (yr_i == 7'd0) ? 7'd99 : yr_i - 7'd1;
                    end else begin
                        mon_o = mon_i - 4'd1;
                    end
                    day_o = month_days(mon_o, yr_o);
                end
            end
        end
    end
endmodule

// File: rtl/msf_frame_decoder.sv
module msf_frame_decoder
    import msf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       byte_valid,
    input  logic       frame_start,
    input  logic [7:0] byte_data,
    output logic [4:0] hours,
    output logic [5:0] minutes,
    output logic [5:0] seconds,
    output logic [2:0] weekday,
    output logic [4:0] day,
    output logic [3:0] month,
    output logic [6:0] year,
    output logic       summer_flag,
    output logic       change_pending,
    output logic       low_battery,
    output logic       resync_failed,
    output logic       rx_ok,
    output logic       time_valid,
    output logic       accept,
    output logic       reject
);
    coll_t c_d, c_q;
    res_t  r_d, r_q;

    logic parity_ok, frame_bits_ok, digit_ok;

    msf_byte_check u_bchk (
        .b            (byte_data),
        .parity_ok    (parity_ok),
        .frame_bits_ok(frame_bits_ok),
        .digit_ok     (digit_ok)
    );

    // decoded fields from the stored digits
    logic [VAL_W-1:0] hr_raw, mn_raw, sc_raw, dy_raw, mo_raw, yr_raw;
    logic [3:0]       wd_raw;
    assign hr_raw = bcd2bin(c_q.dig[D_HT], c_q.dig[D_HU]);
    assign mn_raw = bcd2bin(c_q.dig[D_MT], c_q.dig[D_MU]);
    assign sc_raw = bcd2bin(c_q.dig[D_ST], c_q.dig[D_SU]);
    assign dy_raw = bcd2bin(c_q.dig[D_DT], c_q.dig[D_DU]);
    assign mo_raw = bcd2bin(c_q.dig[D_OT], c_q.dig[D_OU]);
    assign yr_raw = bcd2bin(c_q.dig[D_YT], c_q.dig[D_YU]);
    assign wd_raw = c_q.dig[D_WD];

    logic range_ok, zone_ok, is_summer, ny_clash;
    assign range_ok  = (hr_raw <= 7'd23) && (mn_raw <= 7'd59) && (sc_raw <= 7'd60)
                    && (wd_raw >= 4'd1) && (wd_raw <= 4'd7)
                    && (dy_raw >= 7'd1) && (dy_raw <= 7'd31)
                    && (mo_raw >= 7'd1) && (mo_raw <= 7'd12);
    assign is_summer = c_q.zone[1];
    assign zone_ok   = c_q.zone[1] ^ c_q.zone[2];
    assign ny_clash  = is_summer && (hr_raw == 7'd0) && (dy_raw == 7'd1) && (mo_raw == 7'd1);

    logic [4:0] adj_hour, adj_day;
    logic [2:0] adj_wd;
    logic [3:0] adj_mon;
    logic [6:0] adj_yr;

    msf_utc_adjust u_adj (
        .summer(is_summer),
        .hour_i(hr_raw[4:0]),
        .wd_i  (wd_raw[2:0]),
        .day_i (dy_raw[4:0]),
        .mon_i (mo_raw[3:0]),
        .yr_i  (yr_raw),
        .hour_o(adj_hour),
        .wd_o  (adj_wd),
        .day_o (adj_day),
        .mon_o (adj_mon),
        .yr_o  (adj_yr)
    );

    always_comb begin
        logic [POS_W-1:0] pos;
        logic             open_f;
        logic             bad_now;
        logic             bad_all;
        logic             ok;

        c_d = c_q;
        r_d = r_q;
        r_d.accept = 1'b0;
        r_d.reject = 1'b0;

        pos     = frame_start ? '0 : c_q.pos;
        open_f  = frame_start || c_q.active;
        bad_now = !parity_ok || ((pos < ZONE_POS) ? !digit_ok : !frame_bits_ok);
        bad_all = (frame_start ? 1'b0 : c_q.bad) | bad_now;
        ok      = 1'b0;

        if (byte_valid && open_f) begin
            if (pos < ZONE_POS) begin
                c_d.dig[pos] = byte_data[3:0];
            end
            if (pos == ZONE_POS) begin
                c_d.zone = byte_data[2:0];
            end
            c_d.bad = bad_all;
            if (pos == STATUS_POS) begin
                c_d.active = 1'b0;
                c_d.pos    = '0;
                ok = !bad_all && range_ok && zone_ok && !ny_clash
                  && (byte_data[2:0] == 3'b011);
                r_d.accept    = ok;
                r_d.reject    = !ok;
                r_d.summer    = c_q.zone[1];
                r_d.pending   = c_q.zone[0];
                r_d.low_batt  = byte_data[3];
                r_d.rs_failed = byte_data[2];
                r_d.rx_ok     = byte_data[1];
                r_d.t_valid   = byte_data[0];
                if (ok) begin
                    r_d.hours   = adj_hour;
                    r_d.minutes = mn_raw[5:0];
                    r_d.seconds = sc_raw[5:0];
                    r_d.weekday = adj_wd;
                    r_d.day     = adj_day;
                    r_d.month   = adj_mon;
                    r_d.year    = adj_yr;
                end
            end else begin
                c_d.active = 1'b1;
                c_d.pos    = pos + POS_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q <= '0;
            r_q <= '0;
        end else begin
            c_q <= c_d;
            r_q <= r_d;
        end
    end

    assign hours          = r_q.hours;
    assign minutes        = r_q.minutes;
    assign seconds        = r_q.seconds;
    assign weekday        = r_q.weekday;
    assign day            = r_q.day;
    assign month          = r_q.month;
    assign year           = r_q.year;
    assign summer_flag    = r_q.summer;
    assign change_pending = r_q.pending;
    assign low_battery    = r_q.low_batt;
    assign resync_failed  = r_q.rs_failed;
    assign rx_ok          = r_q.rx_ok;
    assign time_valid     = r_q.t_valid;
    assign accept         = r_q.accept;
    assign reject         = r_q.reject;

endmodule

// File: rtl/msf_frame_decoder_chk.sv
module msf_frame_decoder_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       byte_valid,
    input logic [4:0] hours,
    input logic [5:0] minutes,
    input logic [5:0] seconds,
    input logic [2:0] weekday,
    input logic [4:0] day,
    input logic [3:0] month,
    input logic [6:0] year,
    input logic       summer_flag,
    input logic       resync_failed,
    input logic       rx_ok,
    input logic       time_valid,
    input logic       accept,
    input logic       reject
);
    p_exclusive_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(accept && reject));

    p_one_shot_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (accept || reject) |=> !(accept || reject));

    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |-> ($stable(hours) && $stable(minutes) && $stable(seconds)
                     && $stable(weekday) && $stable(day) && $stable(month) && $stable(year)));

    p_after_byte_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (accept || reject) |-> $past(byte_valid));

    p_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> (hours <= 5'd23 && minutes <= 6'd59 && seconds <= 6'd60
                    && weekday != 3'd0 && day != 5'd0
                    && month >= 4'd1 && month <= 4'd12 && year <= 7'd99));

    p_status_r7: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> (time_valid && rx_ok && !resync_failed));

    p_newyear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && summer_flag) |-> !(month == 4'd12 && day == 5'd31 && hours == 5'd23));
endmodule

bind msf_frame_decoder msf_frame_decoder_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .byte_valid   (byte_valid),
    .hours        (hours),
    .minutes      (minutes),
    .seconds      (seconds),
    .weekday      (weekday),
    .day          (day),
    .month        (month),
    .year         (year),
    .summer_flag  (summer_flag),
    .resync_failed(resync_failed),
    .rx_ok        (rx_ok),
    .time_valid   (time_valid),
    .accept       (accept),
    .reject       (reject)
);

// File: tb/msf_frame_decoder_test.sv
module msf_frame_decoder_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       byte_valid = 1'b0;
    logic       frame_start = 1'b0;
    logic [7:0] byte_data = 8'h00;
    logic [4:0] hours;
    logic [5:0] minutes, seconds;
    logic [2:0] weekday;
    logic [4:0] day;
    logic [3:0] month;
    logic [6:0] year;
    logic summer_flag, change_pending, low_battery, resync_failed, rx_ok, time_valid;
    logic accept, reject;

    int n_chk = 0;
    int n_bad = 0;
    int last_h = 0, last_m = 0, last_s = 0, last_wd = 0, last_d = 0, last_mo = 0, last_y = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    msf_frame_decoder uut (
        .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .frame_start(frame_start),
        .byte_data(byte_data), .hours(hours), .minutes(minutes), .seconds(seconds),
        .weekday(weekday), .day(day), .month(month), .year(year),
        .summer_flag(summer_flag), .change_pending(change_pending),
        .low_battery(low_battery), .resync_failed(resync_failed), .rx_ok(rx_ok),
        .time_valid(time_valid), .accept(accept), .reject(reject)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] enc(input logic [6:0] v);
        return {^v, v};
    endfunction

    task automatic send_byte(input logic [7:0] b, input logic sof);
        byte_valid  = 1'b1;
        frame_start = sof;
        byte_data   = b;
        @(negedge clk);
        byte_valid  = 1'b0;
        frame_start = 1'b0;
    endtask

    // builds and sends a frame; bad_pos >= 0 replaces that byte with bad_val
    task automatic send_frame(input int h, m, s, wd, d, mo, y,
                              input logic bst, utc, pend, input logic [3:0] st,
                              input int bad_pos, input logic [7:0] bad_val);
        logic [7:0] fb [15];
        int v [7];
        v = '{h, m, s, wd, d, mo, y};
        fb[0]  = enc(7'h30 + 7'(h / 10));  fb[1]  = enc(7'h30 + 7'(h % 10));
        fb[2]  = enc(7'h30 + 7'(m / 10));  fb[3]  = enc(7'h30 + 7'(m % 10));
        fb[4]  = enc(7'h30 + 7'(s / 10));  fb[5]  = enc(7'h30 + 7'(s % 10));
        fb[6]  = enc(7'h30 + 7'(wd));
        fb[7]  = enc(7'h30 + 7'(d / 10));  fb[8]  = enc(7'h30 + 7'(d % 10));
        fb[9]  = enc(7'h30 + 7'(mo / 10)); fb[10] = enc(7'h30 + 7'(mo % 10));
        fb[11] = enc(7'h30 + 7'(y / 10));  fb[12] = enc(7'h30 + 7'(y % 10));
        fb[13] = enc({4'b0110, utc, bst, pend});
        fb[14] = enc({3'b011, st});
        if (v[0] < 0) fb[0] = 8'h00;
        if (bad_pos >= 0) fb[bad_pos] = bad_val;
        for (int i = 0; i < 15; i++) send_byte(fb[i], i == 0);
    endtask

    // sampled right after the last byte: verdict due one cycle after it
    task automatic expect_result(input string req, input logic acc,
                                 input int h, m, s, wd, d, mo, y);
        chk(req, "accept", accept, acc);
        chk(req, "reject", reject, !acc);
        if (acc) begin
            last_h = h; last_m = m; last_s = s; last_wd = wd;
            last_d = d; last_mo = mo; last_y = y;
        end
        chk(req, "hours", hours, last_h);
        chk(req, "minutes", minutes, last_m);
        chk(req, "seconds", seconds, last_s);
        chk(req, "weekday", weekday, last_wd);
        chk(req, "day", day, last_d);
        chk(req, "month", month, last_mo);
        chk(req, "year", year, last_y);
        @(negedge clk);
        chk("R11", "pulse gone", accept | reject, 0);
    endtask

    task automatic t_reset();
        chk("R12", "hours", hours, 0);
        chk("R12", "year", year, 0);
        chk("R12", "flags", {summer_flag, change_pending, low_battery, resync_failed, rx_ok, time_valid}, 0);
        chk("R12", "pulses", accept | reject, 0);
    endtask

    task automatic t_basic();
        send_frame(12, 34, 56, 3, 15, 6, 24, 0, 1, 0, 4'b0011, -1, 8'h00);
        chk("R7", "time_valid", time_valid, 1);
        chk("R7", "rx_ok", rx_ok, 1);
        chk("R6", "summer_flag", summer_flag, 0);
        expect_result("R2", 1, 12, 34, 56, 3, 15, 6, 24);
        send_frame(7, 8, 9, 6, 2, 11, 99, 0, 1, 1, 4'b1011, -1, 8'h00);
        chk("R7", "low_battery", low_battery, 1);
        chk("R6", "change_pending", change_pending, 1);
        expect_result("R7", 1, 7, 8, 9, 6, 2, 11, 99);
    endtask

    task automatic t_summer_hour();
        send_frame(10, 5, 0, 5, 20, 7, 23, 1, 0, 0, 4'b0011, -1, 8'h00);
        chk("R6", "summer_flag", summer_flag, 1);
        expect_result("R8", 1, 9, 5, 0, 5, 20, 7, 23);
    endtask

    task automatic t_rollback();
        send_frame(0, 15, 30, 5, 1, 3, 24, 1, 0, 0, 4'b0011, -1, 8'h00);
        expect_result("R9 leap", 1, 23, 15, 30, 4, 29, 2, 24);
        send_frame(0, 0, 0, 3, 1, 3, 23, 1, 0, 0, 4'b0011, -1, 8'h00);
        expect_result("R9 non-leap", 1, 23, 0, 0, 2, 28, 2, 23);
        send_frame(0, 59, 59, 1, 1, 10, 24, 1, 0, 0, 4'b0011, -1, 8'h00);
        expect_result("R9 monday wrap", 1, 23, 59, 59, 7, 30, 9, 24);
        send_frame(0, 10, 0, 4, 1, 8, 25, 1, 0, 0, 4'b0011, -1, 8'h00);
        expect_result("R9 31-day", 1, 23, 10, 0, 3, 31, 7, 25);
        send_frame(0, 20, 0, 2, 17, 5, 22, 1, 0, 0, 4'b0011, -1, 8'h00);
        expect_result("R9 mid-month", 1, 23, 20, 0, 1, 16, 5, 22);
    endtask

    task automatic t_newyear();
        send_frame(0, 30, 0, 1, 1, 1, 24, 1, 0, 0, 4'b0011, -1, 8'h00);
        expect_result("R10", 0, 0, 0, 0, 0, 0, 0, 0);
        send_frame(1, 0, 0, 1, 1, 1, 24, 1, 0, 0, 4'b0011, -1, 8'h00);
        expect_result("R10 second hour", 1, 0, 0, 0, 1, 1, 1, 24);
    endtask

    task automatic t_bytes();
        send_frame(11, 11, 11, 2, 11, 11, 11, 0, 1, 0, 4'b0011, 3, enc(7'h31) ^ 8'h80);
        expect_result("R3", 0, 0, 0, 0, 0, 0, 0, 0);
        send_frame(11, 11, 11, 2, 11, 11, 11, 0, 1, 0, 4'b0011, 7, enc(7'h3A));
        expect_result("R2", 0, 0, 0, 0, 0, 0, 0, 0);
        send_frame(11, 11, 11, 2, 11, 11, 11, 0, 1, 0, 4'b0011, 14, enc(7'b1110011));
        expect_result("R4 status", 0, 0, 0, 0, 0, 0, 0, 0);
        send_frame(11, 11, 11, 2, 11, 11, 11, 0, 1, 0, 4'b0011, 13, enc(7'b0100100));
        expect_result("R4 zone", 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic t_status();
        send_frame(11, 11, 11, 2, 11, 11, 11, 0, 1, 0, 4'b0111, -1, 8'h00);
        chk("R7", "resync_failed", resync_failed, 1);
        expect_result("R7 failed", 0, 0, 0, 0, 0, 0, 0, 0);
        send_frame(11, 11, 11, 2, 11, 11, 11, 0, 1, 0, 4'b0001, -1, 8'h00);
        chk("R7", "rx_ok", rx_ok, 0);
        expect_result("R7 no rx", 0, 0, 0, 0, 0, 0, 0, 0);
        send_frame(11, 11, 11, 2, 11, 11, 11, 0, 1, 0, 4'b0010, -1, 8'h00);
        expect_result("R7 not valid", 0, 0, 0, 0, 0, 0, 0, 0);
        send_frame(11, 11, 11, 2, 11, 11, 11, 1, 1, 0, 4'b0011, -1, 8'h00);
        expect_result("R6 both", 0, 0, 0, 0, 0, 0, 0, 0);
        send_frame(11, 11, 11, 2, 11, 11, 11, 0, 0, 0, 4'b0011, -1, 8'h00);
        expect_result("R6 neither", 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic t_ranges();
        send_frame(24, 0, 0, 2, 11, 11, 11, 0, 1, 0, 4'b0011, -1, 8'h00);
        expect_result("R5 hour", 0, 0, 0, 0, 0, 0, 0, 0);
        send_frame(10, 60, 0, 2, 11, 11, 11, 0, 1, 0, 4'b0011, -1, 8'h00);
        expect_result("R5 minute", 0, 0, 0, 0, 0, 0, 0, 0);
        send_frame(10, 0, 0, 2, 11, 13, 11, 0, 1, 0, 4'b0011, -1, 8'h00);
        expect_result("R5 month", 0, 0, 0, 0, 0, 0, 0, 0);
        send_frame(10, 0, 0, 0, 11, 11, 11, 0, 1, 0, 4'b0011, -1, 8'h00);
        expect_result("R5 weekday", 0, 0, 0, 0, 0, 0, 0, 0);
        send_frame(10, 0, 0, 2, 0, 11, 11, 0, 1, 0, 4'b0011, -1, 8'h00);
        expect_result("R5 day", 0, 0, 0, 0, 0, 0, 0, 0);
        send_frame(10, 0, 61, 2, 11, 11, 11, 0, 1, 0, 4'b0011, -1, 8'h00);
        expect_result("R5 second", 0, 0, 0, 0, 0, 0, 0, 0);
        send_frame(23, 59, 60, 7, 31, 12, 0, 0, 1, 0, 4'b0011, -1, 8'h00);
        expect_result("R5 leap second", 1, 23, 59, 60, 7, 31, 12, 0);
    endtask

    task automatic t_restart();
        int pulses = 0;
        send_byte(enc(7'h32), 1);
        for (int i = 0; i < 5; i++) begin
            send_byte(enc(7'h31), 0);
            pulses += accept | reject;
        end
        chk("R1", "no pulse in partial frame", pulses, 0);
        send_frame(5, 6, 7, 4, 8, 9, 10, 0, 1, 0, 4'b0011, -1, 8'h00);
        expect_result("R1 restart", 1, 5, 6, 7, 4, 8, 9, 10);
    endtask

    task automatic t_stray();
        int pulses = 0;
        for (int i = 0; i < 20; i++) begin
            send_byte(enc(7'h33), 0);
            pulses += accept | reject;
        end
        chk("R1", "stray bytes pulse", pulses, 0);
        chk("R1", "stray hours held", hours, last_h);
        chk("R1", "stray day held", day, last_d);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_bad++;
        $display("FAIL R1 watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_summer_hour();
        t_rollback();
        t_newyear();
        t_bytes();
        t_status();
        t_ranges();
        t_restart();
        t_stray();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule